// File: doc/BRIEF.md
# Single-Channel DMA Block Transfer Sequencer

This block drives one DMA channel through a block transfer that has been programmed in full before it starts. A one-cycle `start` latches the two base addresses (peripheral side and memory side), the item count, the data size of each side, the direction, the two increment enables and the memory-to-memory flag. The block then moves the items one at a time. For each item it wins the bus from an external arbiter, reads one item from the source, writes it to the destination and counts down the items still to move.

Each item is an atomic read-then-write pair on a simple valid/ready read port and write port with a 32-bit byte-laned data bus. The block works out the address, the size and the byte lanes of every beat. It zero-extends or truncates the item when the two sides have different sizes. It steps each address by that side's own item size, or holds it fixed for a peripheral register. In peripheral mode an item is only requested while the peripheral's request line is high. In memory-to-memory mode the channel requests on its own. The request drops for one cycle after every write, so the arbiter can hand the bus to another channel between items.

Top module: `dma_xfer_seq`

## Requirements
- R1: The first read and first write of a block use the latched base addresses. Direction 0 reads from the peripheral address and writes to the memory address. Direction 1 reads from memory and writes to the peripheral.
- R2: Each item is exactly one read handshake (`rd_valid` and `rd_ready`) followed by one write handshake (`wr_valid` and `wr_ready`). While a port waits for ready it keeps valid high and its address stable. The write begins in the cycle after the read handshake.
- R3: `remaining` takes the count at an accepted start. It drops by one in the cycle after each write handshake. When it reaches zero the block stops all bus activity and `busy` goes low.
- R4: Size codes are 00 = byte, 01 = half-word and 10 = word. `rd_size` and `wr_size` carry the size of the side being accessed. An address with increment enabled advances by 1, 2 or 4 for its own size after each item. An address with increment disabled stays fixed.
- R5: The bus is 32 bits wide and byte lane k is bits 8k+7..8k. The read item is taken from `rd_rdata` starting at lane `rd_addr[1:0]`. The written item is placed starting at lane `wr_addr[1:0]`. `wr_strb` has 1, 2 or 4 ones, starting at that lane.
- R6: If the read size is smaller than the write size, the item is zero-extended. If it is larger, the item is truncated to the write size.
- R7: A start with size code 11 on either side, or with a base address not aligned to its side's size, raises `cfg_err`. In that case the block stays idle with no arbiter request. `cfg_err` holds until the next start, and a start with a valid configuration clears it.
- R8: A start with a count of zero leaves the block idle. It gives no `cfg_err` and no `done`.
- R9: `arb_req` is raised only while the block waits for an item and either memory-to-memory mode is set or `periph_req` is high. The read starts in the cycle after `arb_req` and `arb_gnt` are both high. `arb_req` stays high through the write and drops for exactly one cycle after each write handshake that is not the last.
- R10: `done` pulses for one cycle, in the cycle after the write handshake that brings `remaining` to zero.
- R11: A `start` that arrives while `busy` is high is ignored. The running block continues with its latched configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch the configuration and begin a block |
| cfg_per_addr | input | AW | Peripheral-side base address |
| cfg_mem_addr | input | AW | Memory-side base address |
| cfg_count | input | CW | Number of items in the block |
| cfg_per_size | input | 2 | Peripheral item size code |
| cfg_mem_size | input | 2 | Memory item size code |
| cfg_mem_to_per | input | 1 | Direction: 1 reads memory and writes the peripheral |
| cfg_per_inc | input | 1 | Step the peripheral address after each item |
| cfg_mem_inc | input | 1 | Step the memory address after each item |
| cfg_m2m | input | 1 | Memory-to-memory mode: request without `periph_req` |
| periph_req | input | 1 | Peripheral request line |
| arb_req | output | 1 | Request to the arbiter |
| arb_gnt | input | 1 | Grant from the arbiter |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read accepted, `rd_rdata` valid |
| rd_addr | output | AW | Read address |
| rd_size | output | 2 | Read size code |
| rd_rdata | input | 32 | Read data, byte-laned |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write size code |
| wr_strb | output | 4 | Byte-lane write enables |
| wr_data | output | 32 | Write data, byte-laned |
| remaining | output | CW | Items still to move |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse when a block completes |
| cfg_err | output | 1 | The last start was rejected because of its configuration |

## Verification
The assertions assume three things about the block's environment. The arbiter grants only a raised request. `rd_rdata` is meaningful in the cycle `rd_ready` is high. The configuration ports are sampled only at a start, so their value at other times does not matter. The bench keeps to these assumptions by pulsing `arb_gnt` only while it sees `arb_req` high, and by presenting read data only in the `rd_ready` cycle. It draws random sizes, directions, increments, modes, counts and aligned base addresses from a fixed seed, and inserts random wait cycles before each grant and each ready. Directed cases then cover the rejected configurations, a count of zero, a held-off peripheral request and a start while busy.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int BUS_W = 32;
    localparam int LANES = BUS_W / 8;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_REL
    } seq_st_e;

    function automatic logic size_legal(input logic [1:0] sz);
        return sz != 2'b11;
    endfunction

    function automatic logic addr_aligned(input logic [1:0] lo, input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 1'b1;
            SZ_HALF: return lo[0] == 1'b0;
            SZ_WORD: return lo == 2'b00;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] item_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return BUS_W'(32'h0000_00FF);
            SZ_HALF: return BUS_W'(32'h0000_FFFF);
            default: return {BUS_W{1'b1}};
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return LANES'(4'b0001);
            SZ_HALF: return LANES'(4'b0011);
            default: return {LANES{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [1:0]    size,
    input  logic          inc_en,
    output logic [AW-1:0] next_addr
);
    import dma_seq_pkg::*;

    logic [AW-1:0] step;

    always_comb begin
        case (size)
            SZ_BYTE: step = AW'(1);
            SZ_HALF: step = AW'(2);
            default: step = AW'(4);
        endcase
        next_addr = inc_en ? cur_addr + step : cur_addr;
    end
endmodule

// File: rtl/dma_beat_fmt.sv
module dma_beat_fmt
    import dma_seq_pkg::*;
(
    input  logic [BUS_W-1:0] bus_rdata,
    input  logic [1:0]       rd_off,
    input  logic [1:0]       rd_sz,
    input  logic [BUS_W-1:0] held_item,
    input  logic [1:0]       wr_off,
    input  logic [1:0]       wr_sz,
    output logic [BUS_W-1:0] rd_item,
    output logic [BUS_W-1:0] wr_lanes,
    output logic [LANES-1:0] wr_en
);
    logic [BUS_W-1:0] shifted;
    logic [BUS_W-1:0] fitted;

    always_comb begin
        shifted  = bus_rdata >> {rd_off, 3'b000};
        rd_item  = shifted & item_mask(rd_sz);
        fitted   = held_item & item_mask(wr_sz);
        wr_lanes = fitted << {wr_off, 3'b000};
        wr_en    = lane_mask(wr_sz) << wr_off;
    end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cfg_per_addr,
    input  logic [AW-1:0] cfg_mem_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic [1:0]    cfg_per_size,
    input  logic [1:0]    cfg_mem_size,
    input  logic          cfg_mem_to_per,
    input  logic          cfg_per_inc,
    input  logic          cfg_mem_inc,
    input  logic          cfg_m2m,
    input  logic          periph_req,
    output logic          arb_req,
    input  logic          arb_gnt,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [AW-1:0] rd_addr,
    output logic [1:0]    rd_size,
    input  logic [31:0]   rd_rdata,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [1:0]    wr_size,
    output logic [3:0]    wr_strb,
    output logic [31:0]   wr_data,
    output logic [CW-1:0] remaining,
    output logic          busy,
    output logic          done,
    output logic          cfg_err
);
    localparam int SIDES = 2;
    localparam int SIDE_PER = 0;
    localparam int SIDE_MEM = 1;

    typedef struct packed {
        seq_st_e          st;
        logic [AW-1:0]    per_addr;
        logic [AW-1:0]    mem_addr;
        logic [CW-1:0]    left;
        logic [1:0]       per_sz;
        logic [1:0]       mem_sz;
        logic             m2p;
        logic             per_inc;
        logic             mem_inc;
        logic             m2m;
        logic [BUS_W-1:0] item;
        logic             done;
        logic             err;
    } seq_t;

    seq_t q, d;

    logic [AW-1:0] side_addr [SIDES];
    logic [1:0]    side_sz   [SIDES];
    logic          side_inc  [SIDES];
    logic [AW-1:0] side_next [SIDES];

    always_comb begin
        side_addr[SIDE_PER] = q.per_addr;
        side_sz[SIDE_PER]   = q.per_sz;
        side_inc[SIDE_PER]  = q.per_inc;
        side_addr[SIDE_MEM] = q.mem_addr;
        side_sz[SIDE_MEM]   = q.mem_sz;
        side_inc[SIDE_MEM]  = q.mem_inc;
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dma_addr_step #(.AW(AW)) u_step (
            .cur_addr  (side_addr[s]),
            .size      (side_sz[s]),
            .inc_en    (side_inc[s]),
            .next_addr (side_next[s])
        );
    end

    logic [AW-1:0] src_addr, dst_addr;
    logic [1:0]    src_sz, dst_sz;
    logic [BUS_W-1:0] rd_item;

    always_comb begin
        src_addr = q.m2p ? q.mem_addr : q.per_addr;
        dst_addr = q.m2p ? q.per_addr : q.mem_addr;
        src_sz   = q.m2p ? q.mem_sz   : q.per_sz;
        dst_sz   = q.m2p ? q.per_sz   : q.mem_sz;
    end

    dma_beat_fmt u_fmt (
        .bus_rdata (rd_rdata),
        .rd_off    (src_addr[1:0]),
        .rd_sz     (src_sz),
        .held_item (q.item),
        .wr_off    (dst_addr[1:0]),
        .wr_sz     (dst_sz),
        .rd_item   (rd_item),
        .wr_lanes  (wr_data),
        .wr_en     (wr_strb)
    );

    logic cfg_ok;
    logic trig;

    always_comb begin
        cfg_ok = size_legal(cfg_per_size) && size_legal(cfg_mem_size)
              && addr_aligned(cfg_per_addr[1:0], cfg_per_size)
              && addr_aligned(cfg_mem_addr[1:0], cfg_mem_size);
        trig   = q.m2m || periph_req;
    end

    always_comb begin
        arb_req  = (q.st == ST_REQ && trig) || q.st == ST_RD || q.st == ST_WR;
        rd_valid = q.st == ST_RD;
        wr_valid = q.st == ST_WR;
        rd_addr  = src_addr;
        rd_size  = src_sz;
        wr_addr  = dst_addr;
        wr_size  = dst_sz;
        remaining = q.left;
        busy     = q.st != ST_IDLE;
        done     = q.done;
        cfg_err  = q.err;
    end

    always_comb begin
        d = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.err = 1'b0;
                    if (cfg_count != '0) begin
                        if (!cfg_ok) begin
                            d.err = 1'b1;
                        end else begin
                            d.st       = ST_REQ;
                            d.per_addr = cfg_per_addr;
                            d.mem_addr = cfg_mem_addr;
                            d.left     = cfg_count;
                            d.per_sz   = cfg_per_size;
                            d.mem_sz   = cfg_mem_size;
                            d.m2p      = cfg_mem_to_per;
                            d.per_inc  = cfg_per_inc;
                            d.mem_inc  = cfg_mem_inc;
                            d.m2m      = cfg_m2m;
                        end
                    end
                end
            end
            ST_REQ: begin
                if (arb_req && arb_gnt) d.st = ST_RD;
            end
            ST_RD: begin
                if (rd_ready) begin
                    d.item = rd_item;
                    d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (wr_ready) begin
                    d.left     = q.left - CW'(1);
                    d.per_addr = side_next[SIDE_PER];
                    d.mem_addr = side_next[SIDE_MEM];
                    if (q.left == CW'(1)) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_REL;
                    end
                end
            end
            ST_REL: d.st = ST_REQ;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R2: write follows a read handshake directly
    a_r2_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(rd_valid && rd_ready));
    // R2: a waiting read holds its request
    a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
    // R2: a waiting write holds its request
    a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
    // R3: one decrement per completed item
    a_r3_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (remaining == $past(remaining) - CW'(1)));
    // R5: strobes cover 1, 2 or 4 lanes
    a_r5_strb_width: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($countones(wr_strb) == 1 || $countones(wr_strb) == 2
                      || $countones(wr_strb) == 4));
    // R9: reads only after a grant
    a_r9_rd_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(arb_req && arb_gnt));
    // R9: bus released after each write
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !arb_req);
    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: done coincides with an empty count
    a_r10_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (remaining == '0 && !busy));
endmodule

// File: tb/dma_xfer_seq_bench.sv
module dma_xfer_seq_bench;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] cfg_per_addr = '0;
    logic [AW-1:0] cfg_mem_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0]    cfg_per_size = '0;
    logic [1:0]    cfg_mem_size = '0;
    logic          cfg_mem_to_per = 1'b0;
    logic          cfg_per_inc = 1'b0;
    logic          cfg_mem_inc = 1'b0;
    logic          cfg_m2m = 1'b0;
    logic          periph_req = 1'b1;
    logic          arb_req;
    logic          arb_gnt = 1'b0;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [1:0]    rd_size;
    logic [31:0]   rd_rdata = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [1:0]    wr_size;
    logic [3:0]    wr_strb;
    logic [31:0]   wr_data;
    logic [CW-1:0] remaining;
    logic          busy;
    logic          done;
    logic          cfg_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dma_xfer_seq #(.AW(AW), .CW(CW)) u_dma_xfer_seq (
        .clk, .rst_n, .start, .cfg_per_addr, .cfg_mem_addr, .cfg_count,
        .cfg_per_size, .cfg_mem_size, .cfg_mem_to_per, .cfg_per_inc,
        .cfg_mem_inc, .cfg_m2m, .periph_req, .arb_req, .arb_gnt,
        .rd_valid, .rd_ready, .rd_addr, .rd_size, .rd_rdata,
        .wr_valid, .wr_ready, .wr_addr, .wr_size, .wr_strb, .wr_data,
        .remaining, .busy, .done, .cfg_err
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [3:0] strb_of(input logic [1:0] sz, input logic [1:0] off);
        int n = 1 << sz;
        return 4'(((1 << n) - 1) << off);
    endfunction

    function automatic logic [31:0] step_of(input logic [1:0] sz);
        return 32'(1) << sz;
    endfunction

    task automatic do_start(input logic [AW-1:0] pa, input logic [AW-1:0] ma,
                            input logic [CW-1:0] cnt, input logic [1:0] ps,
                            input logic [1:0] ms, input logic dir, input logic pinc,
                            input logic minc, input logic m2m);
        cfg_per_addr = pa; cfg_mem_addr = ma; cfg_count = cnt;
        cfg_per_size = ps; cfg_mem_size = ms; cfg_mem_to_per = dir;
        cfg_per_inc = pinc; cfg_mem_inc = minc; cfg_m2m = m2m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_block(input logic [AW-1:0] pa, input logic [AW-1:0] ma,
                             input logic [CW-1:0] cnt, input logic [1:0] ps,
                             input logic [1:0] ms, input logic dir, input logic pinc,
                             input logic minc, input logic m2m, input bit hold_req,
                             input bit restart_busy);
        logic [31:0] pe = pa;
        logic [31:0] me = ma;
        if (hold_req) periph_req = 1'b0;
        do_start(pa, ma, cnt, ps, ms, dir, pinc, minc, m2m);
        chk(busy == 1'b1 && cfg_err == 1'b0, "R1 busy after start", busy, 1);
        chk(remaining == cnt, "R3 count loaded", remaining, cnt);
        if (restart_busy) begin
            do_start(32'h3, 32'h5, 16'd9, 2'd0, 2'd0, ~dir, 1'b0, 1'b0, 1'b1);
            chk(remaining == cnt && cfg_err == 1'b0, "R11 start while busy ignored",
                remaining, cnt);
        end
        if (hold_req) begin
            for (int k = 0; k < 3; k++) begin
                chk(arb_req == 1'b0, "R9 no request without periph_req", arb_req, 0);
                @(negedge clk);
            end
            periph_req = 1'b1;
        end
        for (int i = 0; i < int'(cnt); i++) begin
            logic [31:0] sa, da, raw, item, expd;
            logic [1:0]  ssz, dsz;
            int w;
            sa  = dir ? me : pe;  da  = dir ? pe : me;
            ssz = dir ? ms : ps;  dsz = dir ? ps : ms;
            w = 0;
            while (!arb_req && w < 20) begin @(negedge clk); w++; end
            chk(arb_req == 1'b1, "R9 request raised", arb_req, 1);
            repeat ($urandom_range(0, 2)) begin
                chk(rd_valid == 1'b0, "R9 no read before grant", rd_valid, 0);
                @(negedge clk);
            end
            arb_gnt = 1'b1;
            @(negedge clk);
            arb_gnt = 1'b0;
            chk(rd_valid == 1'b1, "R9 read after grant", rd_valid, 1);
            chk(rd_addr == sa, "R1 R4 read address", rd_addr, sa);
            chk(rd_size == ssz, "R4 read size", rd_size, ssz);
            repeat ($urandom_range(0, 2)) begin
                @(negedge clk);
                chk(rd_valid && rd_addr == sa, "R2 read held", rd_addr, sa);
            end
            raw = $urandom;
            rd_rdata = raw; rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0; rd_rdata = $urandom;
            item = (raw >> (8 * sa[1:0])) & mask_of(ssz);
            expd = (item & mask_of(dsz)) << (8 * da[1:0]);
            chk(wr_valid == 1'b1 && rd_valid == 1'b0, "R2 write follows read", wr_valid, 1);
            chk(wr_addr == da, "R1 R4 write address", wr_addr, da);
            chk(wr_size == dsz, "R4 write size", wr_size, dsz);
            chk(wr_strb == strb_of(dsz, da[1:0]), "R5 strobes", wr_strb, strb_of(dsz, da[1:0]));
            chk(wr_data == expd, "R5 R6 write data", wr_data, expd);
            repeat ($urandom_range(0, 1)) begin
                @(negedge clk);
                chk(wr_valid && wr_data == expd, "R2 write held", wr_data, expd);
            end
            wr_ready = 1'b1;
            @(negedge clk);
            wr_ready = 1'b0;
            chk(remaining == cnt - CW'(i + 1), "R3 count decrement", remaining, cnt - CW'(i + 1));
            if (pinc) pe = pe + step_of(ps);
            if (minc) me = me + step_of(ms);
            if (i == int'(cnt) - 1) begin
                chk(done == 1'b1 && busy == 1'b0, "R10 done pulse", done, 1);
                @(negedge clk);
                chk(done == 1'b0 && arb_req == 1'b0 && rd_valid == 1'b0,
                    "R3 R10 idle after block", done, 0);
            end else begin
                chk(arb_req == 1'b0 && done == 1'b0, "R9 release between items", arb_req, 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && cfg_err == 0 && arb_req == 0
            && rd_valid == 0 && wr_valid == 0 && remaining == 0,
            "R3 reset state", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: peripheral word to memory bytes (R6 truncation), fixed peripheral address
        run_block(32'h100, 32'h203, 16'd3, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        // directed: memory byte to peripheral word (R6 zero extension), start while busy (R11)
        run_block(32'h40, 32'h1001, 16'd2, 2'd2, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);

        // R7: misaligned half-word base
        do_start(32'h11, 32'h20, 16'd4, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        chk(cfg_err == 1'b1 && busy == 1'b0, "R7 misaligned rejected", cfg_err, 1);
        repeat (2) @(negedge clk);
        chk(arb_req == 1'b0 && cfg_err == 1'b1, "R7 no request after error", arb_req, 0);
        // R7: illegal size code
        do_start(32'h10, 32'h20, 16'd4, 2'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1);
        chk(cfg_err == 1'b1 && busy == 1'b0, "R7 size 11 rejected", cfg_err, 1);
        // R8: count zero
        do_start(32'h10, 32'h20, 16'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        chk(cfg_err == 1'b0 && busy == 1'b0 && done == 1'b0, "R8 zero count idle", busy, 0);
        @(negedge clk);
        chk(done == 1'b0 && arb_req == 1'b0, "R8 no done for zero count", done, 0);

        for (int b = 0; b < 30; b++) begin
            logic [1:0] ps, ms;
            logic [31:0] pa, ma;
            ps = 2'($urandom_range(0, 2));
            ms = 2'($urandom_range(0, 2));
            pa = ($urandom & 32'hFFFF) & ~(step_of(ps) - 1);
            ma = ($urandom & 32'hFFFF) & ~(step_of(ms) - 1);
            run_block(pa, ma, CW'($urandom_range(1, 6)), ps, ms, 1'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule